// File: doc/BRIEF.md
# Hexadecimal Add/Subtract Calculator Controller

This block sequences a two-operand hexadecimal calculator. Keypad nibbles arrive with a one-cycle valid strobe. Four synchronized one-cycle button pulses (add, subtract, equals, clear) steer a three-state machine. The states are: first operand being typed, second operand being typed, and result on show. Each digit shifts the active 16-bit register up by one nibble and places itself in the lowest nibble.

Pressing add or subtract while the first operand is being typed latches the chosen operation into a one-bit flag. It also starts a blank second operand. Equals later applies whichever operation the flag records. The sum or difference lands in the accumulator and wraps modulo 2^16, because overflow and borrow are not flagged.

The single output is the 16-bit value to be drawn on a display. While the second operand is typed it shows that operand. In every other state it shows the accumulator.

Top module: `hex_calc_ctrl`

## Requirements
- R1: After synchronous reset the display value is 0 and the block is in first-operand entry.
- R2: In first-operand entry a valid digit with no button pulse makes the accumulator (and the display) equal to the previous value shifted left by 4 bits with the digit in bits 3:0; the top nibble is lost.
- R3: In first-operand entry an add or subtract pulse moves to second-operand entry, zeroes the operand register so the display reads 0, and sets the operation flag to 1 for add or 0 for subtract.
- R4: In second-operand entry a valid digit shifts the operand register the same way as R2, the display shows the operand register, and the accumulator is untouched.
- R5: In second-operand entry an equals pulse with the flag at 1 stores (accumulator + operand) mod 2^16 in the accumulator, enters show-result, and the display shows that sum.
- R6: In second-operand entry an equals pulse with the flag at 0 stores (accumulator - operand) mod 2^16 in the accumulator, enters show-result, and the display shows that difference.
- R7: In show-result a valid digit starts a new first operand: the accumulator becomes the digit zero-extended, the operand register is zeroed, and the block returns to first-operand entry.
- R8: A clear pulse in any state zeroes both registers and returns to first-operand entry, so the display reads 0 on the next cycle.
- R9: Clear takes priority over every other button and over a digit arriving in the same cycle.
- R10: When a button pulse and a valid digit arrive together, the button is acted on and the digit is discarded.
- R11: When add and subtract pulse in the same cycle, add wins and the flag is set to 1.
- R12: Equals is ignored in first-operand entry and in show-result. Add and subtract are ignored in second-operand entry and in show-result, and leave the flag unchanged. "Ignored" means the display is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_nib | input | NIB_W (4) | Keypad digit value |
| key_vld | input | 1 | One-cycle strobe qualifying key_nib |
| btn_add | input | 1 | One-cycle add operator pulse |
| btn_sub | input | 1 | One-cycle subtract operator pulse |
| btn_eq | input | 1 | One-cycle execute pulse |
| btn_clr | input | 1 | One-cycle clear pulse |
| disp | output | NIB_W*N_DIGITS (16) | Value to be displayed |

## Verification
Operand pairs are swept over a grid that includes 0, 0xFFFF, 0x8000 and scattered mixed-nibble values, under both operations. Each result is compared with the sum or difference computed arithmetically. This separates a swapped operation flag, a wrong operand order in subtraction, and missing wrap-around at either end of the range. The partial display is checked after every keystroke, which exposes a wrong shift direction or a wrong nibble position. Coincident pulses (clear with a digit, operator with a digit, add with subtract) and buttons pressed in states where they must do nothing are applied one by one. This checks the priority order and that stray pulses cannot alter the register on show or the latched flag.

// File: rtl/hexcalc_pkg.sv
package hexcalc_pkg;

    typedef enum logic [1:0] {
        ST_OPA  = 2'd0,
        ST_OPB  = 2'd1,
        ST_SHOW = 2'd2
    } calc_state_t;

    typedef enum logic {
        OP_SUB = 1'b0,
        OP_ADD = 1'b1
    } calc_op_t;

    // one-hot command after priority resolution
    typedef struct packed {
        logic clr;
        logic add;
        logic sub;
        logic eq;
        logic dig;
    } cmd_t;

    // per-register update controls
    typedef struct packed {
        logic clr;
        logic load;
        logic fresh;
        logic shift;
    } reg_ctl_t;

    // clear > add > sub > eq > digit
    function automatic cmd_t resolve_cmd(logic clr, logic add, logic sub,
                                         logic eq, logic dig);
        cmd_t c;
        c = '0;
        if (clr)      c.clr = 1'b1;
        else if (add) c.add = 1'b1;
        else if (sub) c.sub = 1'b1;
        else if (eq)  c.eq  = 1'b1;
        else if (dig) c.dig = 1'b1;
        return c;
    endfunction

endpackage

// File: rtl/hexcalc_fsm.sv
module hexcalc_fsm
    import hexcalc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        key_vld,
    input  logic        btn_add,
    input  logic        btn_sub,
    input  logic        btn_eq,
    input  logic        btn_clr,
    output calc_state_t st_q,
    output calc_op_t    op_q,
    output reg_ctl_t    acc_ctl,
    output reg_ctl_t    opb_ctl
);

    cmd_t        cmd;
    calc_state_t st_d;

    assign cmd = resolve_cmd(btn_clr, btn_add, btn_sub, btn_eq, key_vld);

    always_comb begin
        st_d    = st_q;
        acc_ctl = '0;
        opb_ctl = '0;
        if (cmd.clr) begin
            st_d        = ST_OPA;
            acc_ctl.clr = 1'b1;
            opb_ctl.clr = 1'b1;
        end else begin
            unique case (st_q)
                ST_OPA: begin
                    if (cmd.add || cmd.sub) begin
                        st_d        = ST_OPB;
                        opb_ctl.clr = 1'b1;
                    end else if (cmd.dig) begin
                        acc_ctl.shift = 1'b1;
                    end
                end
                ST_OPB: begin
                    if (cmd.eq) begin
                        st_d         = ST_SHOW;
                        acc_ctl.load = 1'b1;
                    end else if (cmd.dig) begin
                        opb_ctl.shift = 1'b1;
                    end
                end
                ST_SHOW: begin
                    if (cmd.dig) begin
                        st_d          = ST_OPA;
                        acc_ctl.fresh = 1'b1;
                        opb_ctl.clr   = 1'b1;
                    end
                end
                default: st_d = ST_OPA;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_OPA;
            op_q <= OP_ADD;
        end else begin
            st_q <= st_d;
            if (st_q == ST_OPA && cmd.add)      op_q <= OP_ADD;
            else if (st_q == ST_OPA && cmd.sub) op_q <= OP_SUB;
        end
    end

endmodule

// File: rtl/hexcalc_nibreg.sv
module hexcalc_nibreg
    import hexcalc_pkg::*;
#(
    parameter int W  = 16,
    parameter int NW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  reg_ctl_t      ctl,
    input  logic [NW-1:0] nib,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  q
);

    logic [W-1:0] shifted;

    generate
        if (W > NW) begin : g_wide
            assign shifted = {q[W-NW-1:0], nib};
        end else begin : g_single
            assign shifted = W'(nib);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || ctl.clr)  q <= '0;
        else if (ctl.load)   q <= din;
        else if (ctl.fresh)  q <= W'(nib);
        else if (ctl.shift)  q <= shifted;
    end

endmodule

// File: rtl/hexcalc_alu.sv
module hexcalc_alu
    import hexcalc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  calc_op_t     op,
    output logic [W-1:0] y
);

    always_comb begin
        if (op == OP_ADD) y = a + b;
        else              y = a - b;
    end

endmodule

// File: rtl/hex_calc_ctrl.sv
module hex_calc_ctrl
    import hexcalc_pkg::*;
#(
    parameter int NIB_W    = 4,
    parameter int N_DIGITS = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NIB_W-1:0]          key_nib,
    input  logic                      key_vld,
    input  logic                      btn_add,
    input  logic                      btn_sub,
    input  logic                      btn_eq,
    input  logic                      btn_clr,
    output logic [NIB_W*N_DIGITS-1:0] disp
);

    localparam int WORD_W = NIB_W * N_DIGITS;

    calc_state_t       st_q;
    calc_op_t          op_q;
    reg_ctl_t          acc_ctl;
    reg_ctl_t          opb_ctl;
    logic [WORD_W-1:0] acc_q;
    logic [WORD_W-1:0] opb_q;
    logic [WORD_W-1:0] alu_y;

    hexcalc_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .key_vld (key_vld),
        .btn_add (btn_add),
        .btn_sub (btn_sub),
        .btn_eq  (btn_eq),
        .btn_clr (btn_clr),
        .st_q    (st_q),
        .op_q    (op_q),
        .acc_ctl (acc_ctl),
        .opb_ctl (opb_ctl)
    );

    hexcalc_nibreg #(.W(WORD_W), .NW(NIB_W)) u_acc (
        .clk (clk),
        .rst (rst),
        .ctl (acc_ctl),
        .nib (key_nib),
        .din (alu_y),
        .q   (acc_q)
    );

    hexcalc_nibreg #(.W(WORD_W), .NW(NIB_W)) u_opb (
        .clk (clk),
        .rst (rst),
        .ctl (opb_ctl),
        .nib (key_nib),
        .din ('0),
        .q   (opb_q)
    );

    hexcalc_alu #(.W(WORD_W)) u_alu (
        .a  (acc_q),
        .b  (opb_q),
        .op (op_q),
        .y  (alu_y)
    );

    always_comb begin
        if (st_q == ST_OPB) disp = opb_q;
        else                disp = acc_q;
    end

endmodule

// File: rtl/hexcalc_chk.sv
module hexcalc_chk
    import hexcalc_pkg::*;
#(
    parameter int W  = 16,
    parameter int NW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic [NW-1:0] key_nib,
    input logic          key_vld,
    input logic          btn_add,
    input logic          btn_sub,
    input logic          btn_eq,
    input logic          btn_clr,
    input logic [W-1:0]  disp,
    input calc_state_t   st,
    input calc_op_t      op,
    input logic [W-1:0]  acc,
    input logic [W-1:0]  opb
);

    logic         any_btn;
    logic [W-1:0] shl_w;
    logic [W-1:0] zext_w;
    logic [W-1:0] sum_w;
    logic [W-1:0] dif_w;

    assign any_btn = btn_add | btn_sub | btn_eq | btn_clr;
    assign shl_w   = (disp << NW) | W'(key_nib);
    assign zext_w  = W'(key_nib);
    assign sum_w   = acc + opb;
    assign dif_w   = acc - opb;

    assert_legal_state_R1: assert property (@(posedge clk) disable iff (rst)
        (st == ST_OPA || st == ST_OPB || st == ST_SHOW))
        else $error("state encoding illegal");

    assert_digit_shift_R2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_OPA && key_vld && !any_btn) |=> disp == $past(shl_w))
        else $error("first operand shift wrong");

    assert_op_enter_R3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_OPA && !btn_clr && (btn_add || btn_sub)) |=> (st == ST_OPB && disp == '0))
        else $error("operator entry wrong");

    assert_add_flag_R11: assert property (@(posedge clk) disable iff (rst)
        (st == ST_OPA && !btn_clr && btn_add) |=> op == OP_ADD)
        else $error("add flag not latched");

    assert_opb_shift_R4: assert property (@(posedge clk) disable iff (rst)
        (st == ST_OPB && key_vld && !any_btn) |=> (disp == $past(shl_w) && $stable(acc)))
        else $error("second operand shift wrong");

    assert_sum_R5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_OPB && btn_eq && !btn_clr && !btn_add && !btn_sub && op == OP_ADD)
        |=> (st == ST_SHOW && disp == $past(sum_w)))
        else $error("sum wrong");

    assert_diff_R6: assert property (@(posedge clk) disable iff (rst)
        (st == ST_OPB && btn_eq && !btn_clr && !btn_add && !btn_sub && op == OP_SUB)
        |=> (st == ST_SHOW && disp == $past(dif_w)))
        else $error("difference wrong");

    assert_fresh_R7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SHOW && key_vld && !any_btn) |=> (st == ST_OPA && disp == $past(zext_w)))
        else $error("fresh operand wrong");

    assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
        btn_clr |=> (st == ST_OPA && acc == '0 && opb == '0))
        else $error("clear wrong");

    assert_flag_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (st != ST_OPA) |=> $stable(op))
        else $error("flag changed outside first entry");

endmodule

bind hex_calc_ctrl hexcalc_chk #(.W(WORD_W), .NW(NIB_W)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .key_nib (key_nib),
    .key_vld (key_vld),
    .btn_add (btn_add),
    .btn_sub (btn_sub),
    .btn_eq  (btn_eq),
    .btn_clr (btn_clr),
    .disp    (disp),
    .st      (st_q),
    .op      (op_q),
    .acc     (acc_q),
    .opb     (opb_q)
);

// File: tb/hex_calc_ctrl_tb_top.sv
`timescale 1ns/1ps
module hex_calc_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  key_nib = '0;
    logic        key_vld = 1'b0;
    logic        btn_add = 1'b0;
    logic        btn_sub = 1'b0;
    logic        btn_eq  = 1'b0;
    logic        btn_clr = 1'b0;
    logic [15:0] disp;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    hex_calc_ctrl dut_i (
        .clk     (clk),
        .rst     (rst),
        .key_nib (key_nib),
        .key_vld (key_vld),
        .btn_add (btn_add),
        .btn_sub (btn_sub),
        .btn_eq  (btn_eq),
        .btn_clr (btn_clr),
        .disp    (disp)
    );

    // one-cycle stimulus applied at a falling edge, result read at the next falling edge
    task automatic drive(input logic [3:0] k, input logic v, input logic a,
                         input logic s, input logic e, input logic c);
        @(negedge clk);
        key_nib = k; key_vld = v; btn_add = a; btn_sub = s; btn_eq = e; btn_clr = c;
        @(negedge clk);
        key_nib = '0; key_vld = 0; btn_add = 0; btn_sub = 0; btn_eq = 0; btn_clr = 0;
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: disp=%h expected %h", tag, act, exp);
        end
    endtask

    task automatic digit(input logic [3:0] d);
        drive(d, 1, 0, 0, 0, 0);
    endtask

    task automatic enter(input logic [15:0] v);
        for (int i = 3; i >= 0; i--) digit(v[i*4 +: 4]);
    endtask

    function automatic logic [15:0] vec(input int i);
        if (i == 0) return 16'h0000;
        if (i == 1) return 16'hFFFF;
        if (i == 2) return 16'h8000;
        return 16'(i * 16'h3A7D) ^ 16'h0C5F;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1..: run did not complete");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] e;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset display", disp, 16'h0000);

        // R2: first operand, every keystroke
        e = '0;
        for (int i = 3; i >= 0; i--) begin
            digit(16'hA5C3 >> (i * 4));
            e = {e[11:0], 4'(16'hA5C3 >> (i * 4))};
            chk("R2 first operand shift", disp, e);
        end
        digit(4'h9);
        chk("R2 top nibble dropped", disp, 16'h5C39);

        // R3 / R4 / R5
        drive(0, 0, 1, 0, 0, 0);
        chk("R3 add clears operand view", disp, 16'h0000);
        e = '0;
        for (int i = 3; i >= 0; i--) begin
            digit(16'h1234 >> (i * 4));
            e = {e[11:0], 4'(16'h1234 >> (i * 4))};
            chk("R4 second operand shift", disp, e);
        end
        drive(0, 0, 0, 0, 1, 0);
        chk("R5 sum", disp, 16'((16'h5C39 + 16'h1234)));

        // R7 fresh operand, then R6 subtract
        digit(4'h7);
        chk("R7 fresh operand", disp, 16'h0007);
        digit(4'h0); digit(4'h0); digit(4'h1);
        chk("R7 continues as first operand", disp, 16'h7001);
        drive(0, 0, 0, 1, 0, 0);
        chk("R3 sub clears operand view", disp, 16'h0000);
        digit(4'h2);
        drive(0, 0, 0, 0, 1, 0);
        chk("R6 difference", disp, 16'h6FFF);

        // R6 wrap below zero
        drive(0, 0, 0, 0, 0, 1);
        enter(16'h0001);
        drive(0, 0, 0, 1, 0, 0);
        enter(16'h0002);
        drive(0, 0, 0, 0, 1, 0);
        chk("R6 borrow wraps", disp, 16'hFFFF);

        // R8 clear mid second operand; R12 equals ignored in first entry
        drive(0, 0, 0, 0, 0, 1);
        enter(16'h0012);
        drive(0, 0, 1, 0, 0, 0);
        enter(16'h0034);
        drive(0, 0, 0, 0, 0, 1);
        chk("R8 clear", disp, 16'h0000);
        drive(0, 0, 0, 0, 1, 0);
        chk("R12 equals ignored in first entry", disp, 16'h0000);
        digit(4'h5);
        chk("R8 back in first entry", disp, 16'h0005);

        // R9 clear beats digit
        drive(4'h9, 1, 0, 0, 0, 1);
        chk("R9 clear over digit", disp, 16'h0000);
        digit(4'h3);
        chk("R9 first entry after clear", disp, 16'h0003);

        // R10 operator beats digit
        drive(4'hE, 1, 1, 0, 0, 0);
        chk("R10 digit discarded with operator", disp, 16'h0000);
        digit(4'h4);
        drive(0, 0, 0, 0, 1, 0);
        chk("R10 result after operator+digit", disp, 16'h0007);

        // R11 add wins over sub
        drive(0, 0, 0, 0, 0, 1);
        enter(16'h0050);
        drive(0, 0, 1, 1, 0, 0);
        chk("R11 both operators enter second", disp, 16'h0000);
        enter(16'h0020);
        drive(0, 0, 0, 0, 1, 0);
        chk("R11 add chosen", disp, 16'h0070);

        // R12 stray operators ignored
        drive(0, 0, 0, 0, 0, 1);
        enter(16'h0050);
        drive(0, 0, 0, 1, 0, 0);
        enter(16'h0020);
        drive(0, 0, 1, 0, 0, 0);
        chk("R12 add ignored in second entry", disp, 16'h0020);
        drive(0, 0, 0, 0, 1, 0);
        chk("R12 flag kept as subtract", disp, 16'h0030);
        drive(0, 0, 0, 0, 1, 0);
        chk("R12 equals ignored in result", disp, 16'h0030);
        drive(0, 0, 1, 0, 0, 0);
        chk("R12 add ignored in result", disp, 16'h0030);
        drive(0, 0, 0, 1, 0, 0);
        chk("R12 sub ignored in result", disp, 16'h0030);
        digit(4'h1);
        chk("R7 digit after ignored buttons", disp, 16'h0001);

        // R5 / R6 sweep
        for (int i = 0; i < 12; i++) begin
            for (int j = 0; j < 12; j++) begin
                for (int op = 0; op < 2; op++) begin
                    drive(0, 0, 0, 0, 0, 1);
                    enter(vec(i));
                    drive(0, 0, op == 0, op == 1, 0, 0);
                    enter(vec(j));
                    drive(0, 0, 0, 0, 1, 0);
                    if (op == 0) chk("R5 sweep sum", disp, 16'(vec(i) + vec(j)));
                    else         chk("R6 sweep difference", disp, 16'(vec(i) - vec(j)));
                end
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule